// File: doc/BRIEF.md
# Skewed Iteration Domain Generator

This block produces the index stream of a doubly nested loop after a skewing transform. The unskewed loop visits every point of an N by K rectangle: an outer index from 1 to N and an inner index from 1 to K. After skewing, the outer index s runs over the anti-diagonals, from 2 to N+K. For each s, the inner index i covers the part of that diagonal that lies inside the rectangle. Each visited point leaves the block as an operand index pair: the y index is i and the x index is s-i.

A start pulse latches N, K and the stream mode. Points are then offered one at a time in skewed loop order, each under a valid/ready handshake. In single-stream mode every point goes to stream 0. In split mode, points on even diagonals go to stream 0 and points on odd diagonals go to stream 1, so that two copies of the downstream function can share the work. Each stream has its own ready signal. Only one point is outstanding at any time. A one-cycle done pulse marks the end of the domain.

Top module: `skew_domain_gen`

## Requirements
- R1: After reset, both stream valids, done and busy are low.
- R2: A start pulse while idle latches n_in, k_in and split_in. A start pulse while busy is ignored, and the running sequence is unchanged.
- R3: The diagonal index s=x+y steps from 2 to N+K. Within each s, y rises by 1 from max(1, s-N) to min(s-1, K).
- R4: Every point presents y_idx = i and x_idx = s-i, with 1 <= y_idx <= K and 1 <= x_idx <= N.
- R5: Exactly N*K points are transferred per run.
- R6: While a stream's valid is high and its ready is low, that valid stays high and y_idx/x_idx stay unchanged.
- R7: With split_in=0, every point uses stream 0 and s1_valid stays low. With split_in=1, a point goes to stream 1 when x_idx+y_idx is odd and to stream 0 when it is even. At most one valid is high at a time.
- R8: In split mode, a point advances only on the ready of its own stream. The other stream's ready has no effect on it.
- R9: done is high for exactly one cycle, in the cycle after the last point (y_idx=K, x_idx+y_idx=N+K) is transferred. busy is low in that same cycle.
- R10: After done, a new start pulse begins a fresh domain with the newly applied parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a domain (taken only when idle) |
| n_in | input | N_W | Outer extent N (N >= 1) |
| k_in | input | K_W | Inner extent K (K >= 1) |
| split_in | input | 1 | 1 selects two-stream parity split |
| s0_valid | output | 1 | Stream 0 point valid |
| s0_ready | input | 1 | Stream 0 accept |
| s1_valid | output | 1 | Stream 1 point valid |
| s1_ready | input | 1 | Stream 1 accept |
| y_idx | output | K_W | Inner operand index i |
| x_idx | output | N_W | Outer operand index s-i |
| done | output | 1 | One-cycle end-of-domain pulse |
| busy | output | 1 | A domain is in progress |

## Verification
The bench targets the diagonal transitions where the lower bound switches from 1 to s-N and the upper bound switches from s-1 to K. It uses both K < N and K > N, so both orders of those switches occur. A faulty bound would skip or repeat points, and the point count and order checks would then show a mismatch. Random per-stream ready patterns in split mode catch a design that advances on the wrong stream's ready, or that moves the index bus during a stall. A start pulse in the middle of a run catches a design that re-latches its parameters. The checks on the cycle after the final point catch a done pulse that comes early, comes late, or is missing.

// File: rtl/skew_pkg.sv
// Shared types for the skewed domain generator.
package skew_pkg;
    // Sequencer state: idle, waiting for start, or walking the domain.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_t;
endpackage

// File: rtl/skew_bounds.sv
// Combinational bound unit.
// Computes the inner upper bound for the current diagonal, min(s-1, K),
// and the inner lower bound for the following diagonal, max(1, s+1-N).
// Assumes J_W is wide enough to hold N+K+1 without wrap.
module skew_bounds #(
    parameter int N_W = 10,
    parameter int K_W = 6,
    parameter int J_W = N_W + 1
) (
    input  logic [J_W-1:0] j_cur,
    input  logic [N_W-1:0] n_lim,
    input  logic [K_W-1:0] k_lim,
    output logic [J_W-1:0] hi_cur,
    output logic [J_W-1:0] lo_next
);
    logic [J_W-1:0] n_ext;
    logic [J_W-1:0] k_ext;
    logic [J_W-1:0] j_dec;
    logic [J_W-1:0] j_inc;

    // Purpose: widen operands and form the neighbouring diagonal indices.
    always_comb begin
        n_ext = J_W'(n_lim);
        k_ext = J_W'(k_lim);
        j_dec = j_cur - J_W'(1);
        j_inc = j_cur + J_W'(1);
    end

    // Purpose: clip the diagonal against the rectangle edges.
    always_comb begin
        hi_cur  = (j_dec < k_ext) ? j_dec : k_ext;
        lo_next = (j_inc > n_ext) ? (j_inc - n_ext) : J_W'(1);
    end
endmodule

// File: rtl/skew_seq.sv
// Domain sequencer.
// Holds the latched parameters and the (diagonal, inner) counter pair, and
// steps them by one point per accepted transfer. It raises done for one
// cycle after the final point. Assumes N >= 1 and K >= 1, so the first
// diagonal (s = 2) always starts at inner index 1.
module skew_seq
    import skew_pkg::*;
#(
    parameter int N_W = 10,
    parameter int K_W = 6,
    parameter int J_W = N_W + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N_W-1:0] n_in,
    input  logic [K_W-1:0] k_in,
    input  logic           split_in,
    input  logic           pt_ready,
    output logic           pt_valid,
    output logic [J_W-1:0] j_q,
    output logic [J_W-1:0] i_q,
    output logic [N_W-1:0] n_q,
    output logic [K_W-1:0] k_q,
    output logic           split_q,
    output logic           done,
    output logic           busy
);
    seq_state_t     state_q;
    logic [J_W-1:0] hi_cur;
    logic [J_W-1:0] lo_next;
    logic [J_W-1:0] last_j;
    logic           row_end;
    logic           dom_end;
    logic           fire;
    logic           done_q;

    skew_bounds #(.N_W(N_W), .K_W(K_W), .J_W(J_W)) u_bounds (
        .j_cur   (j_q),
        .n_lim   (n_q),
        .k_lim   (k_q),
        .hi_cur  (hi_cur),
        .lo_next (lo_next)
    );

    // Purpose: decode transfer and end-of-row / end-of-domain conditions.
    always_comb begin
        last_j   = J_W'(n_q) + J_W'(k_q);
        pt_valid = (state_q == ST_RUN);
        fire     = pt_valid && pt_ready;
        row_end  = (i_q == hi_cur);
        dom_end  = row_end && (j_q == last_j);
    end

    // Purpose: latch parameters on start and advance the point counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            j_q     <= '0;
            i_q     <= '0;
            n_q     <= '0;
            k_q     <= '0;
            split_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        n_q     <= n_in;
                        k_q     <= k_in;
                        split_q <= split_in;
                        j_q     <= J_W'(2);
                        i_q     <= J_W'(1);
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (fire) begin
                        if (dom_end) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else if (row_end) begin
                            j_q <= j_q + J_W'(1);
                            i_q <= lo_next;
                        end else begin
                            i_q <= i_q + J_W'(1);
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: drive status outputs from registered state.
    always_comb begin
        done = done_q;
        busy = (state_q == ST_RUN);
    end
endmodule

// File: rtl/skew_route.sv
// Stream router.
// Steers the single outstanding point to stream 0 or stream 1. In split
// mode an odd diagonal selects stream 1. The point's ready is taken only
// from the selected stream.
module skew_route (
    input  logic split_q,
    input  logic j_odd,
    input  logic pt_valid,
    input  logic s0_ready,
    input  logic s1_ready,
    output logic s0_valid,
    output logic s1_valid,
    output logic pt_ready
);
    logic to_s1;

    // Purpose: pick the target stream and return its ready.
    always_comb begin
        to_s1    = split_q && j_odd;
        s0_valid = pt_valid && !to_s1;
        s1_valid = pt_valid && to_s1;
        pt_ready = to_s1 ? s1_ready : s0_ready;
    end
endmodule

// File: rtl/skew_domain_gen.sv
// Skewed iteration domain generator, top level.
// Walks the diagonals s = 2 .. N+K of an N x K rectangle. For each point
// it emits y = i and x = s - i, on one stream or split by diagonal parity
// across two. Assumes N >= 1, K >= 1 and K < 2**N_W.
module skew_domain_gen #(
    parameter int N_W = 10,
    parameter int K_W = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N_W-1:0] n_in,
    input  logic [K_W-1:0] k_in,
    input  logic           split_in,
    output logic           s0_valid,
    input  logic           s0_ready,
    output logic           s1_valid,
    input  logic           s1_ready,
    output logic [K_W-1:0] y_idx,
    output logic [N_W-1:0] x_idx,
    output logic           done,
    output logic           busy
);
    localparam int J_W = N_W + 1;

    logic           pt_valid;
    logic           pt_ready;
    logic [J_W-1:0] j_q;
    logic [J_W-1:0] i_q;
    logic [N_W-1:0] n_q;
    logic [K_W-1:0] k_q;
    logic           split_q;

    skew_seq #(.N_W(N_W), .K_W(K_W), .J_W(J_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .n_in     (n_in),
        .k_in     (k_in),
        .split_in (split_in),
        .pt_ready (pt_ready),
        .pt_valid (pt_valid),
        .j_q      (j_q),
        .i_q      (i_q),
        .n_q      (n_q),
        .k_q      (k_q),
        .split_q  (split_q),
        .done     (done),
        .busy     (busy)
    );

    skew_route u_route (
        .split_q  (split_q),
        .j_odd    (j_q[0]),
        .pt_valid (pt_valid),
        .s0_ready (s0_ready),
        .s1_ready (s1_ready),
        .s0_valid (s0_valid),
        .s1_valid (s1_valid),
        .pt_ready (pt_ready)
    );

    // Purpose: form the operand index pair from the counters.
    always_comb begin
        y_idx = K_W'(i_q);
        x_idx = N_W'(j_q - i_q);
    end
endmodule

// File: rtl/skew_domain_gen_chk.sv
// Assertion checker for skew_domain_gen, attached by bind.
// Observes the ports and the latched parameters.
module skew_domain_gen_chk #(
    parameter int N_W = 10,
    parameter int K_W = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           s0_valid,
    input logic           s0_ready,
    input logic           s1_valid,
    input logic           s1_ready,
    input logic [K_W-1:0] y_idx,
    input logic [N_W-1:0] x_idx,
    input logic           done,
    input logic           busy,
    input logic [N_W-1:0] n_q,
    input logic [K_W-1:0] k_q,
    input logic           split_q
);
    logic fire;
    logic last_pt;
    int   diag;

    // Purpose: decode transfer and final-point conditions.
    always_comb begin
        fire    = (s0_valid && s0_ready) || (s1_valid && s1_ready);
        diag    = int'(x_idx) + int'(y_idx);
        last_pt = (int'(y_idx) == int'(k_q)) && (diag == int'(n_q) + int'(k_q));
    end

    a_r6_hold_s0: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_valid && !s0_ready) |=> (s0_valid && $stable(y_idx) && $stable(x_idx)));

    a_r8_hold_s1: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !s1_ready) |=> (s1_valid && $stable(y_idx) && $stable(x_idx)));

    a_r7_one_stream: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({s0_valid, s1_valid}));

    a_r7_unsplit_s0: assert property (@(posedge clk) disable iff (!rst_n)
        !split_q |-> !s1_valid);

    a_r7_odd_on_s1: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> (diag % 2 == 1));

    a_r7_even_on_s0: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_valid && split_q) |-> (diag % 2 == 0));

    a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_valid || s1_valid) |->
            (y_idx >= K_W'(1) && y_idx <= k_q && x_idx >= N_W'(1) && x_idx <= n_q));

    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !last_pt) |=>
            (busy && ((int'(y_idx) == int'($past(y_idx)) + 1 && diag == $past(diag))
                      || diag == $past(diag) + 1)));

    a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && last_pt) |=> (done && !busy));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind skew_domain_gen skew_domain_gen_chk #(.N_W(N_W), .K_W(K_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .s0_valid (s0_valid),
    .s0_ready (s0_ready),
    .s1_valid (s1_valid),
    .s1_ready (s1_ready),
    .y_idx    (y_idx),
    .x_idx    (x_idx),
    .done     (done),
    .busy     (busy),
    .n_q      (n_q),
    .k_q      (k_q),
    .split_q  (split_q)
);

// File: tb/skew_domain_gen_tb.sv
`timescale 1ns/1ps
module skew_domain_gen_tb;
    localparam int N_W = 10;
    localparam int K_W = 6;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           start;
    logic [N_W-1:0] n_in;
    logic [K_W-1:0] k_in;
    logic           split_in;
    logic           s0_valid, s0_ready, s1_valid, s1_ready;
    logic [K_W-1:0] y_idx;
    logic [N_W-1:0] x_idx;
    logic           done, busy;

    int errors = 0;
    int checks = 0;
    int exp_i[$];
    int exp_s[$];
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    skew_domain_gen #(.N_W(N_W), .K_W(K_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .n_in(n_in), .k_in(k_in),
        .split_in(split_in), .s0_valid(s0_valid), .s0_ready(s0_ready),
        .s1_valid(s1_valid), .s1_ready(s1_ready), .y_idx(y_idx), .x_idx(x_idx),
        .done(done), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference domain: diagonal walk with clipped inner bounds.
    task automatic build_ref(input int n, input int k);
        exp_i.delete();
        exp_s.delete();
        for (int s = 2; s <= n + k; s++) begin
            int lo = (s - n > 1) ? s - n : 1;
            int hi = (s - 1 < k) ? s - 1 : k;
            for (int i = lo; i <= hi; i++) begin
                exp_i.push_back(i);
                exp_s.push_back(s);
            end
        end
    endtask

    task automatic run_case(input int n, input int k, input bit split,
                            input bit rnd, input bit mid);
        int cyc = 0;
        int got = 0;
        bit last_pend = 0;
        bit hold0 = 0, hold1 = 0;
        int py = 0, px = 0;
        build_ref(n, k);
        @(negedge clk);
        n_in = N_W'(n); k_in = K_W'(k); split_in = split; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R10", "busy after start", int'(busy), 1);
        while (1) begin
            if (last_pend) begin
                check(done == 1'b1 && busy == 1'b0, "R9", "done/busy after last",
                      {30'd0, done, busy}, 2);
                check(got == n * k, "R5", "point count", got, n * k);
                if (mid) check(got == n * k, "R2", "count with ignored start", got, n * k);
                break;
            end
            if (done) check(1'b0, "R9", "early done", 1, 0);
            if (rnd) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                s0_ready = lfsr[0];
                s1_ready = lfsr[5];
            end else begin
                s0_ready = 1'b1;
                s1_ready = 1'b1;
            end
            if (mid && cyc == 5) begin
                start = 1'b1; n_in = N_W'(n + 3); k_in = K_W'(k + 1); split_in = !split;
            end
            if (mid && cyc == 6) start = 1'b0;
            if (hold0) check(s0_valid && int'(y_idx) == py && int'(x_idx) == px,
                             split ? "R8" : "R6", "stream0 stall hold", int'(y_idx), py);
            if (hold1) check(s1_valid && int'(y_idx) == py && int'(x_idx) == px,
                             "R8", "stream1 stall hold", int'(y_idx), py);
            if (s0_valid && s1_valid) check(1'b0, "R7", "both valids", 2, 1);
            if (s0_valid || s1_valid) begin
                if (exp_i.size() == 0) begin
                    check(1'b0, "R3", "extra point", int'(y_idx), 0);
                end else begin
                    int ei = exp_i[0];
                    int es = exp_s[0];
                    bit want1 = split && (es % 2 == 1);
                    bit fire;
                    check(s1_valid == want1, "R7", "stream select", int'(s1_valid), int'(want1));
                    check(int'(y_idx) == ei, "R3", "inner index order", int'(y_idx), ei);
                    check(int'(x_idx) == es - ei, "R4", "x index", int'(x_idx), es - ei);
                    fire = s1_valid ? s1_ready : s0_ready;
                    if (fire) begin
                        void'(exp_i.pop_front());
                        void'(exp_s.pop_front());
                        got++;
                        if (exp_i.size() == 0) last_pend = 1;
                    end
                end
            end
            hold0 = s0_valid && !s0_ready;
            hold1 = s1_valid && !s1_ready;
            py = int'(y_idx);
            px = int'(x_idx);
            cyc++;
            if (cyc > 120000) begin
                check(1'b0, "R5", "watchdog expired", got, n * k);
                break;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; n_in = '0; k_in = '0; split_in = 1'b0;
        s0_ready = 1'b0; s1_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!s0_valid && !s1_valid && !done && !busy, "R1", "reset outputs",
              {28'd0, s0_valid, s1_valid, done, busy}, 0);
        run_case(5, 3, 1'b0, 1'b0, 1'b1);     // K < N, ignored mid-run start
        run_case(2, 4, 1'b1, 1'b1, 1'b0);     // K > N, split, random ready
        run_case(7, 7, 1'b1, 1'b0, 1'b0);     // square, split
        run_case(100, 8, 1'b1, 1'b1, 1'b1);   // split, stalls, ignored start
        run_case(1000, 48, 1'b0, 1'b0, 1'b0); // largest extents
        run_case(100, 48, 1'b0, 1'b1, 1'b0);  // single stream with stalls
        @(negedge clk);
        check(!busy && !done, "R10", "idle after runs", int'(busy), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule